// File: doc/BRIEF.md
# Memory Ordering Gate

This block sits between an in-order stream of memory operations and the memory port. It decides, cycle by cycle, whether the operation at the head of the stream may issue. The stream carries four kinds of operation: plain data accesses, fences, acquires and releases. Each kind is held back only as long as weak ordering or release consistency requires. Data accesses and the two synchronization kinds go to memory and later return a completion. A fence is passed to the issue port for visibility but returns no completion.

A saturating up/down counter tracks data accesses that are in flight. One flag marks an acquire that has not completed and another marks a release that has not completed. The head operation is accepted in the same cycle that it appears on the issue port, so the stream handshake and the issue strobe are the same event. Completions arrive on their own port, at most one per cycle, each tagged with its kind.

Top module: `fence_order_unit`

## Requirements
- R1: After reset nothing is in flight. A data access or a fence offered at the head is accepted at once. With `op_valid_i` low, `iss_valid_o` stays low.
- R2: The in-flight count rises by one when a data access issues. It falls by one when a data completion arrives (kind code 0 on `cmp_kind_i`). Both in the same cycle leave it unchanged. A data completion while the count is zero is ignored.
- R3: A data access is held (`op_ready_o` low) while 15 data accesses are in flight.
- R4: A fence (kind code 1) is accepted only when no data access, acquire or release is in flight. Because the stream is in order, every operation behind it waits.
- R5: While an acquire (kind code 2) is outstanding, no operation of any kind is accepted. An acquire completion (code 2 on `cmp_kind_i`) clears this condition.
- R6: An acquire is accepted while data accesses are still in flight, provided no other acquire is outstanding.
- R7: A release (kind code 3) is accepted only when no data access, acquire or release is in flight. A release completion (code 3 on `cmp_kind_i`) clears the outstanding release.
- R8: Data accesses and acquires behind an outstanding release are accepted without waiting for it.
- R9: `iss_valid_o` equals `op_valid_i && op_ready_o` in the same cycle, and `iss_kind_o` then equals `op_kind_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Head of stream holds an operation |
| op_kind_i | input | 2 | Kind: 0 data, 1 fence, 2 acquire, 3 release |
| op_ready_o | output | 1 | Head operation is accepted this cycle |
| iss_valid_o | output | 1 | Operation issued to memory |
| iss_kind_o | output | 2 | Kind of the issued operation |
| cmp_valid_i | input | 1 | A completion returns |
| cmp_kind_i | input | 2 | Kind of the completing operation |

## Verification
A wrong in-flight count or a stuck flag shows up in `op_ready_o` within the cycle, because ready is combinational from state. A fence or release presented at the head exposes whether the count reads zero. A data access exposes saturation or a pending acquire. The bench keeps its own count and flags and compares ready and issue every cycle, so any drift is reported on the first cycle in which the affected kind is offered.

// File: rtl/fence_order_pkg.sv
package fence_order_pkg;
  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_FENCE = 2'd1,
    KIND_ACQ   = 2'd2,
    KIND_REL   = 2'd3
  } op_kind_e;

  localparam int unsigned NUM_SYNC_FLAGS = 2;
  localparam int unsigned FLAG_ACQ = 0;
  localparam int unsigned FLAG_REL = 1;
endpackage

// File: rtl/fence_order_cnt.sv
module fence_order_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a decrement at zero is dropped
  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc_i, dec_i && (cnt_q != '0)})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign full_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/fence_order_flag.sv
module fence_order_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/fence_order_gate.sv
module fence_order_gate
  import fence_order_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_full_i,
  input  logic       acq_pend_i,
  input  logic       rel_pend_i,
  output logic       ready_o
);
  logic drained;

  assign drained = cnt_zero_i && !acq_pend_i && !rel_pend_i;

  always_comb begin
    unique case (op_kind_e'(kind_i))
      KIND_DATA:  ready_o = !acq_pend_i && !cnt_full_i;
      KIND_FENCE: ready_o = drained;
      KIND_ACQ:   ready_o = !acq_pend_i;
      KIND_REL:   ready_o = drained;
      default:    ready_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fence_order_unit.sv
module fence_order_unit
  import fence_order_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       op_valid_i,
  input  logic [1:0] op_kind_i,
  output logic       op_ready_o,
  output logic       iss_valid_o,
  output logic [1:0] iss_kind_o,
  input  logic       cmp_valid_i,
  input  logic [1:0] cmp_kind_i
);
  logic [CNT_W-1:0]          cnt_q;
  logic                      cnt_zero, cnt_full;
  logic                      fire;
  logic [NUM_SYNC_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic                      acq_pend, rel_pend;

  assign fire = op_valid_i && op_ready_o;

  fence_order_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (fire && (op_kind_i == KIND_DATA)),
    .dec_i  (cmp_valid_i && (cmp_kind_i == KIND_DATA)),
    .cnt_o  (cnt_q),
    .zero_o (cnt_zero),
    .full_o (cnt_full)
  );

  assign flag_set[FLAG_ACQ] = fire && (op_kind_i == KIND_ACQ);
  assign flag_clr[FLAG_ACQ] = cmp_valid_i && (cmp_kind_i == KIND_ACQ);
  assign flag_set[FLAG_REL] = fire && (op_kind_i == KIND_REL);
  assign flag_clr[FLAG_REL] = cmp_valid_i && (cmp_kind_i == KIND_REL);

  for (genvar g = 0; g < NUM_SYNC_FLAGS; g++) begin : g_flag
    fence_order_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  assign acq_pend = flag_q[FLAG_ACQ];
  assign rel_pend = flag_q[FLAG_REL];

  fence_order_gate u_gate (
    .kind_i     (op_kind_i),
    .cnt_zero_i (cnt_zero),
    .cnt_full_i (cnt_full),
    .acq_pend_i (acq_pend),
    .rel_pend_i (rel_pend),
    .ready_o    (op_ready_o)
  );

  assign iss_valid_o = fire;
  assign iss_kind_o  = op_kind_i;
endmodule

// File: rtl/fence_order_unit_chk.sv
module fence_order_unit_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [1:0]       op_kind_i,
  input logic             iss_valid_o,
  input logic [1:0]       iss_kind_o,
  input logic             cmp_valid_i,
  input logic [1:0]       cmp_kind_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic             acq_pend,
  input logic             rel_pend
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic iss_data, cmp_data;
  assign iss_data = iss_valid_o && (iss_kind_o == 2'd0);
  assign cmp_data = cmp_valid_i && (cmp_kind_i == 2'd0);

  // R2
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_data && !cmp_data) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_data && cmp_data) |=> $stable(cnt_q));

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_data |-> (cnt_q != CNT_MAX));

  // R4
  fence_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_kind_o == 2'd1) |-> (cnt_q == '0 && !acq_pend && !rel_pend));

  // R5
  acq_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> !acq_pend);

  // R7
  rel_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_kind_o == 2'd3) |-> (cnt_q == '0 && !rel_pend));

  // R9
  iss_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> (op_valid_i && iss_kind_o == op_kind_i));
endmodule

bind fence_order_unit fence_order_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_kind_i   (op_kind_i),
  .iss_valid_o (iss_valid_o),
  .iss_kind_o  (iss_kind_o),
  .cmp_valid_i (cmp_valid_i),
  .cmp_kind_i  (cmp_kind_i),
  .cnt_q       (cnt_q),
  .acq_pend    (acq_pend),
  .rel_pend    (rel_pend)
);

// File: tb/fence_order_unit_tb.sv
module fence_order_unit_tb;
  localparam int CLK_HALF = 4;
  localparam int CNT_MAX  = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic       op_ready;
  logic       iss_valid;
  logic [1:0] iss_kind;
  logic       cmp_valid = 1'b0;
  logic [1:0] cmp_kind = 2'd0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  int  m_cnt = 0;
  bit  m_acq = 1'b0;
  bit  m_rel = 1'b0;

  always #CLK_HALF clk = ~clk;

  fence_order_unit u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .op_valid_i  (op_valid),
    .op_kind_i   (op_kind),
    .op_ready_o  (op_ready),
    .iss_valid_o (iss_valid),
    .iss_kind_o  (iss_kind),
    .cmp_valid_i (cmp_valid),
    .cmp_kind_i  (cmp_kind)
  );

  function automatic bit exp_ready(input logic [1:0] k);
    bit drained = (m_cnt == 0) && !m_acq && !m_rel;
    case (k)
      2'd0:    return !m_acq && (m_cnt != CNT_MAX);
      2'd1:    return drained;
      2'd2:    return !m_acq;
      default: return drained;
    endcase
  endfunction

  function automatic string req_tag(input logic [1:0] k);
    case (k)
      2'd0:    return m_acq ? "R5" : (m_cnt == CNT_MAX) ? "R3" : m_rel ? "R8" : "R2";
      2'd1:    return "R4";
      2'd2:    return m_acq ? "R5" : (m_cnt != 0) ? "R6" : "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // drive one cycle, check before the edge, then advance the model
  task automatic step(input bit v, input logic [1:0] k, input bit cv, input logic [1:0] ck);
    bit er, fire;
    @(negedge clk);
    op_valid = v; op_kind = k; cmp_valid = cv; cmp_kind = ck;
    #1;
    er = exp_ready(k);
    check(req_tag(k), {31'd0, op_ready}, {31'd0, er});
    fire = v && er;
    check("R9", {29'd0, iss_valid, iss_valid ? iss_kind : 2'd0},
          {29'd0, fire, fire ? k : 2'd0});
    if (fire && k == 2'd0) m_cnt++;
    if (cv && ck == 2'd0 && m_cnt > 0 && !(fire && k == 2'd0 && m_cnt == 1 && 0)) m_cnt--;
    if (fire && k == 2'd2) m_acq = 1'b1;
    else if (cv && ck == 2'd2) m_acq = 1'b0;
    if (fire && k == 2'd3) m_rel = 1'b1;
    else if (cv && ck == 2'd3) m_rel = 1'b0;
  endtask

  task automatic rand_cmp(output bit cv, output logic [1:0] ck);
    int r = $urandom_range(0, 99);
    cv = 1'b0; ck = 2'd0;
    if (m_acq && r < 25)            begin cv = 1'b1; ck = 2'd2; end
    else if (m_rel && r < 45)       begin cv = 1'b1; ck = 2'd3; end
    else if (m_cnt > 0 && r < 85)   begin cv = 1'b1; ck = 2'd0; end
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0bd1));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); op_valid = 1'b0; op_kind = 2'd0; #1;
    check("R1", {31'd0, iss_valid}, 32'd0);
    check("R1", {31'd0, op_ready}, 32'd1);
    op_kind = 2'd1; #1;
    check("R1", {31'd0, op_ready}, 32'd1);

    // R3 saturate with no completions
    for (int i = 0; i < CNT_MAX; i++) step(1'b1, 2'd0, 1'b0, 2'd0);
    step(1'b1, 2'd0, 1'b0, 2'd0);          // held at 15
    step(1'b1, 2'd1, 1'b0, 2'd0);          // R4 fence held
    step(1'b1, 2'd2, 1'b0, 2'd0);          // R6 acquire goes with data in flight
    step(1'b1, 2'd0, 1'b1, 2'd0);          // R5 data blocked by acquire
    step(1'b1, 2'd0, 1'b1, 2'd2);          // R5 still blocked in completion cycle
    step(1'b1, 2'd0, 1'b1, 2'd0);          // R2 issue + completion
    step(1'b1, 2'd0, 1'b0, 2'd0);          // R3 saturated again
    // drain, then release path
    for (int i = 0; i < CNT_MAX; i++) step(1'b0, 2'd0, 1'b1, 2'd0);
    step(1'b0, 2'd0, 1'b1, 2'd0);          // R2 completion at zero ignored
    step(1'b1, 2'd3, 1'b0, 2'd0);          // R7 release issues when drained
    step(1'b1, 2'd0, 1'b0, 2'd0);          // R8 data passes pending release
    step(1'b1, 2'd3, 1'b0, 2'd0);          // R7 second release held
    step(1'b1, 2'd1, 1'b1, 2'd0);          // R4 fence held by pending release
    step(1'b1, 2'd1, 1'b1, 2'd3);          // R4 still held in completion cycle
    step(1'b1, 2'd1, 1'b0, 2'd0);          // R4 fence issues

    for (int i = 0; i < 4000; i++) begin
      bit cv; logic [1:0] ck; int r; logic [1:0] k;
      rand_cmp(cv, ck);
      r = $urandom_range(0, 99);
      k = (r < 64) ? 2'd0 : (r < 76) ? 2'd1 : (r < 88) ? 2'd2 : 2'd3;
      step($urandom_range(0, 9) < 8, k, cv, ck);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule